// File: doc/BRIEF.md
# Dual-Edge Byte Serializer for Conversion Results

This block takes 16-bit conversion results, delays them by a fixed pipeline latency and puts each one on an 8-bit bus in two halves within one clock cycle. The upper byte is driven while the clock is high, after the rising edge. The lower byte is driven while the clock is low, after the falling edge. A receiver rebuilds the word by pairing each rising-edge byte with the falling-edge byte that follows it.

In three-colour mode a pixel takes three clock cycles. The output slots run red, green, blue, and the pixel sampling strobe fixes where that sequence starts. Each result carries a colour tag, and it is only put out when the tag matches the slot it reaches. In single-channel mode every clock cycle is one pixel and the tag is ignored. The latency is 12 cycles in three-colour mode and 10 in single-channel mode; both are parameters. A change of mode flushes the pipeline. After a reset or a flush the bus stays at zero and the valid flag stays low until new results have passed through.

Top module: `ddr_byte_serializer`

## Requirements
- R1: While rst_ni is low, byte_o is zero, valid_o is low and color_o is 0, in both clock phases.
- R2: After a rising edge that loads a result, byte_o carries bits [15:8] of it while clk_i is high. After the falling edge that follows, byte_o carries bits [7:0] while clk_i is low.
- R3: In three-colour mode (three_ch_i = 1), a result presented at rising edge e comes out in the clock cycle that starts at rising edge e+12.
- R4: In single-channel mode (three_ch_i = 0), a result presented at rising edge e comes out in the clock cycle that starts at rising edge e+10.
- R5: In three-colour mode the output slots follow the order red (code 0), green (code 1), blue (code 2), then wrap to red. A slot whose delayed input had strobe_i high is red. A result comes out only if its res_tag_i equals its slot code; tag 3 never matches. color_o shows the slot code while valid_o is high.
- R6: In three-colour mode, after a reset or a mode change, no result comes out until a delayed strobe has reached the output. The slot carrying that strobe is the first that can be valid.
- R7: In single-channel mode every valid result comes out whatever its tag, and color_o stays 0.
- R8: At a rising edge where three_ch_i differs from the current mode, the pipeline is flushed. Results presented at or before that edge never come out, and the output is invalid for the following cycle.
- R9: In any cycle whose result is not output (no result, wrong tag, not locked, flushed), valid_o is low, color_o is 0 and byte_o is zero in both phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Converter clock; both edges drive the output |
| rst_ni | input | 1 | Asynchronous active-low reset |
| three_ch_i | input | 1 | 1 = three-colour mode, 0 = single-channel mode |
| strobe_i | input | 1 | Pixel sampling strobe; marks the red slot |
| res_valid_i | input | 1 | A result is present this cycle |
| res_tag_i | input | 2 | Colour tag of the result: 0 red, 1 green, 2 blue |
| res_data_i | input | 16 | Conversion result |
| byte_o | output | 8 | Upper byte while clock high, lower byte while clock low |
| valid_o | output | 1 | The current cycle carries a result |
| color_o | output | 2 | Slot code of the current result, 0 when invalid |

## Verification
Two events can meet at one rising edge: a mode-change flush, and a valid result arriving at the pipeline tail. The bench provokes this by switching mode while the pipeline is full of matching three-colour results. It then checks that the output stays zero and invalid, and that no pre-change result comes out later. A second meeting is an early strobe landing on a slot the counter would have made blue. That is provoked from the stimulus table and judged by the colour and word of each rebuilt cycle.

// File: rtl/ddr_byte_serializer_pkg.sv
package ddr_byte_serializer_pkg;
  typedef enum logic [1:0] {
    COL_RED   = 2'd0,
    COL_GREEN = 2'd1,
    COL_BLUE  = 2'd2,
    COL_NONE  = 2'd3
  } color_e;
endpackage

// File: rtl/ser_pipe.sv
module ser_pipe #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 12,
  parameter int TAP_A  = 12,
  parameter int TAP_B  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              sel_a_i,
  input  logic              vld_i,
  input  logic              stb_i,
  input  logic [1:0]        tag_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic              stb_o,
  output logic [1:0]        tag_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int ENT_W = DATA_W + 4;

  logic [ENT_W-1:0] ent_q [DEPTH];
  logic [ENT_W-1:0] ent_in;
  logic [ENT_W-1:0] tap;

  assign ent_in = {vld_i, stb_i, tag_i, data_i};

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      ent_q[0] <= '0;
        else if (flush_i) ent_q[0] <= '0;
        else              ent_q[0] <= ent_in;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      ent_q[i] <= '0;
        else if (flush_i) ent_q[i] <= '0;
        else              ent_q[i] <= ent_q[i-1];
      end
    end
  end

  assign tap    = sel_a_i ? ent_q[TAP_A-1] : ent_q[TAP_B-1];
  assign vld_o  = tap[ENT_W-1];
  assign stb_o  = tap[ENT_W-2];
  assign tag_o  = tap[DATA_W+1:DATA_W];
  assign data_o = tap[DATA_W-1:0];
endmodule

// File: rtl/ser_slot.sv
module ser_slot
  import ddr_byte_serializer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       three_ch_i,
  input  logic       tap_vld_i,
  input  logic       tap_stb_i,
  input  logic [1:0] tap_tag_i,
  output logic       take_o,
  output logic [1:0] color_o
);
  color_e slot_q, slot_d;
  logic   locked_q;
  logic   lock_ok;

  always_comb begin
    if (tap_stb_i)             slot_d = COL_RED;
    else if (slot_q == COL_BLUE) slot_d = COL_RED;
    else                       slot_d = color_e'(slot_q + 2'd1);
  end

  assign lock_ok = locked_q | tap_stb_i;
  assign take_o  = three_ch_i ? (tap_vld_i & lock_ok & (tap_tag_i == slot_d)) : tap_vld_i;
  assign color_o = (three_ch_i & take_o) ? slot_d : COL_RED;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= COL_RED;
      locked_q <= 1'b0;
    end else if (flush_i) begin
      slot_q   <= COL_RED;
      locked_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      if (three_ch_i && tap_stb_i) locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ser_ddr_out.sv
module ser_ddr_out #(
  parameter int DATA_W = 16,
  localparam int BYTE_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [1:0]        color_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o,
  output logic [1:0]        color_o
);
  logic [DATA_W-1:0] word_q;
  logic [BYTE_W-1:0] lo_q;
  logic              valid_q;
  logic [1:0]        color_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      color_q <= '0;
    end else begin
      word_q  <= load_i ? word_i : '0;
      valid_q <= load_i;
      color_q <= load_i ? color_i : 2'd0;
    end
  end

  // low half follows on the falling edge of the same cycle
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lo_q <= '0;
    else         lo_q <= word_q[BYTE_W-1:0];
  end

  assign byte_o  = clk_i ? word_q[DATA_W-1:BYTE_W] : lo_q;
  assign valid_o = valid_q;
  assign color_o = color_q;
endmodule

// File: rtl/ddr_byte_serializer.sv
module ddr_byte_serializer #(
  parameter int DATA_W  = 16,
  parameter int LAT_3CH = 12,
  parameter int LAT_1CH = 10,
  localparam int BYTE_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              three_ch_i,
  input  logic              strobe_i,
  input  logic              res_valid_i,
  input  logic [1:0]        res_tag_i,
  input  logic [DATA_W-1:0] res_data_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o,
  output logic [1:0]        color_o
);
  localparam int DEPTH = (LAT_3CH > LAT_1CH) ? LAT_3CH : LAT_1CH;

  logic              mode_q;
  logic              flush;
  logic              tap_vld, tap_stb, take;
  logic [1:0]        tap_tag, tap_color;
  logic [DATA_W-1:0] tap_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b1;
    else         mode_q <= three_ch_i;
  end

  assign flush = three_ch_i != mode_q;

  ser_pipe #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .TAP_A(LAT_3CH), .TAP_B(LAT_1CH)
  ) u_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush), .sel_a_i(mode_q),
    .vld_i(res_valid_i), .stb_i(strobe_i), .tag_i(res_tag_i), .data_i(res_data_i),
    .vld_o(tap_vld), .stb_o(tap_stb), .tag_o(tap_tag), .data_o(tap_data)
  );

  ser_slot u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush), .three_ch_i(mode_q),
    .tap_vld_i(tap_vld), .tap_stb_i(tap_stb), .tap_tag_i(tap_tag),
    .take_o(take), .color_o(tap_color)
  );

  ser_ddr_out #(.DATA_W(DATA_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(take & ~flush),
    .word_i(tap_data), .color_i(tap_color),
    .byte_o(byte_o), .valid_o(valid_o), .color_o(color_o)
  );
endmodule

// File: rtl/ddr_byte_serializer_chk.sv
module ddr_byte_serializer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       three_ch_i,
  input logic       mode_q,
  input logic       valid_o,
  input logic [1:0] color_o
);
  p_color_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    color_o != 2'd3);

  p_color_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && valid_o && $past(valid_o) && color_o != 2'd0)
      |-> color_o == $past(color_o) + 2'd1);

  p_single_red_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && valid_o) |-> color_o == 2'd0);

  p_flush_invalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (three_ch_i != mode_q) |=> !valid_o);

  p_idle_color_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> color_o == 2'd0);
endmodule

bind ddr_byte_serializer ddr_byte_serializer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .three_ch_i(three_ch_i),
  .mode_q(mode_q), .valid_o(valid_o), .color_o(color_o)
);

// File: tb/ddr_byte_serializer_bench.sv
`timescale 1ns/1ps
module ddr_byte_serializer_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        three_ch_i = 1'b1;
  logic        strobe_i = 1'b0;
  logic        res_valid_i = 1'b0;
  logic [1:0]  res_tag_i = 2'd0;
  logic [15:0] res_data_i = 16'd0;
  logic [7:0]  byte_o;
  logic        valid_o;
  logic [1:0]  color_o;

  always #2 clk = ~clk;

  ddr_byte_serializer u_ddr_byte_serializer (
    .clk_i(clk), .rst_ni(rst_ni), .three_ch_i(three_ch_i), .strobe_i(strobe_i),
    .res_valid_i(res_valid_i), .res_tag_i(res_tag_i), .res_data_i(res_data_i),
    .byte_o(byte_o), .valid_o(valid_o), .color_o(color_o)
  );

  // {strobe, valid, tag[1:0], data[15:0], expected_out}
  localparam int NVEC = 18;
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 2'd0, 16'hA1B2, 1'b1},
    {1'b0, 1'b1, 2'd1, 16'h1234, 1'b1},
    {1'b0, 1'b1, 2'd2, 16'hFFEE, 1'b1},
    {1'b1, 1'b1, 2'd0, 16'h0F0F, 1'b1},
    {1'b0, 1'b1, 2'd2, 16'h5555, 1'b0},
    {1'b0, 1'b1, 2'd2, 16'hC3D4, 1'b1},
    {1'b1, 1'b1, 2'd0, 16'h8001, 1'b1},
    {1'b0, 1'b1, 2'd1, 16'h7E7E, 1'b1},
    {1'b0, 1'b0, 2'd2, 16'hDEAD, 1'b0},
    {1'b1, 1'b1, 2'd0, 16'h00FF, 1'b1},
    {1'b0, 1'b1, 2'd1, 16'hFF00, 1'b1},
    {1'b0, 1'b1, 2'd2, 16'h2468, 1'b1},
    {1'b1, 1'b1, 2'd0, 16'h1357, 1'b1},
    {1'b0, 1'b1, 2'd1, 16'h9ABC, 1'b1},
    {1'b1, 1'b1, 2'd0, 16'hBEEF, 1'b1},
    {1'b0, 1'b1, 2'd1, 16'hCAFE, 1'b1},
    {1'b0, 1'b1, 2'd2, 16'h0001, 1'b1},
    {1'b0, 1'b1, 2'd3, 16'h4242, 1'b0}
  };

  int n_chk = 0;
  int n_bad = 0;
  int c = 0;
  int last_flush = 0;
  logic mq = 1'b1;
  logic locked = 1'b0;
  int slot = 0;

  logic        h_stb [0:1023];
  logic        h_vld [0:1023];
  logic [1:0]  h_tag [0:1023];
  logic [15:0] h_dat [0:1023];
  logic        h_mode [0:1023];
  logic        h_tf [0:1023];
  logic        h_te [0:1023];

  task automatic check(input logic ok, input string rq, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic cycle(input logic s, input logic v, input logic [1:0] t,
                       input logic [15:0] d, input logic md, input logic tf,
                       input logic te, input string rq);
    int idx, e, lat;
    logic ok, ev, estb;
    logic [1:0] ecol;
    logic [15:0] edat;
    logic [7:0] hi, lo;
    logic gv;
    logic [1:0] gc;
    idx = c + 1;
    h_stb[idx] = s; h_vld[idx] = v; h_tag[idx] = t; h_dat[idx] = d;
    h_mode[idx] = md; h_tf[idx] = tf; h_te[idx] = te;
    strobe_i = s; res_valid_i = v; res_tag_i = t; res_data_i = d; three_ch_i = md;
    @(posedge clk);
    c++;
    ev = 1'b0; ecol = 2'd0; edat = 16'd0;
    if (h_mode[c] != mq) begin
      last_flush = c; locked = 1'b0; slot = 0; mq = h_mode[c];
    end else begin
      lat  = mq ? 12 : 10;
      e    = c - lat;
      ok   = (e > last_flush) && (e >= 1);
      estb = ok && h_stb[e];
      if (mq) begin
        slot = estb ? 0 : ((slot == 2) ? 0 : slot + 1);
        ev   = ok && h_vld[e] && (locked || estb) && (h_tag[e] == 2'(slot));
        if (ok && h_tf[e]) ev = h_te[e];
        ecol = ev ? 2'(slot) : 2'd0;
        if (estb) locked = 1'b1;
      end else begin
        ev = ok && h_vld[e];
      end
      if (ev) edat = h_dat[e];
    end
    #1;
    hi = byte_o; gv = valid_o; gc = color_o;
    @(negedge clk);
    #1;
    lo = byte_o;
    check(gv == ev, rq, "valid", gv, ev);
    check(gc == ecol, rq, "color", gc, ecol);
    check({hi, lo} == edat, {rq, " R2 R9"}, "word", {hi, lo}, edat);
  endtask

  task automatic idle(input int n, input logic md, input string rq);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 2'd0, 16'd0, md, 1'b0, 1'b0, rq);
  endtask

  task automatic do_reset(input logic md);
    rst_ni = 1'b0;
    strobe_i = 1'b0; res_valid_i = 1'b0; three_ch_i = md;
    #1;
    check(byte_o == 8'd0 && valid_o == 1'b0 && color_o == 2'd0, "R1", "reset state",
          {byte_o, 1'b0, valid_o, color_o}, 0);
    repeat (2) @(posedge clk);
    #1;
    check(byte_o == 8'd0, "R1", "reset high phase", byte_o, 0);
    @(negedge clk);
    #1;
    check(byte_o == 8'd0 && !valid_o, "R1", "reset low phase", byte_o, 0);
    rst_ni = 1'b1;
    last_flush = c; locked = 1'b0; slot = 0; mq = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      h_stb[i] = 0; h_vld[i] = 0; h_tag[i] = 0; h_dat[i] = 0;
      h_mode[i] = 1; h_tf[i] = 0; h_te[i] = 0;
    end
    @(negedge clk);
    do_reset(1'b1);

    // R3 R5: table walk in three-colour mode, including early strobe and bad tags
    for (int i = 0; i < NVEC; i++)
      cycle(VEC[i][20], VEC[i][19], VEC[i][18:17], VEC[i][16:1], 1'b1, 1'b1, VEC[i][0], "R3 R5");
    idle(14, 1'b1, "R3 R5");

    // R8: fill with matching pixels, then switch to single-channel mid-flight
    for (int i = 0; i < 6; i++)
      cycle(i % 3 == 0, 1'b1, 2'(i % 3), 16'h3000 + 16'(i), 1'b1, 1'b0, 1'b0, "R8");
    cycle(1'b1, 1'b1, 2'd0, 16'h7777, 1'b0, 1'b0, 1'b0, "R8");
    // R4 R7 R9: single-channel stream, all tags, gaps
    for (int i = 0; i < 12; i++)
      cycle(1'b1, (i % 5) != 3, 2'(i), 16'h5A00 + 16'(i * 17), 1'b0, 1'b0, 1'b0, "R4 R7");
    idle(11, 1'b0, "R4 R7 R8");

    // R6: back to three-colour; results before the first strobe are held back
    cycle(1'b0, 1'b1, 2'd0, 16'h6601, 1'b1, 1'b0, 1'b0, "R6");
    cycle(1'b0, 1'b1, 2'd1, 16'h6602, 1'b1, 1'b0, 1'b0, "R6");
    cycle(1'b0, 1'b1, 2'd1, 16'h6603, 1'b1, 1'b0, 1'b0, "R6");
    cycle(1'b0, 1'b1, 2'd2, 16'h6604, 1'b1, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 6; i++)
      cycle(i % 3 == 0, 1'b1, 2'(i % 3), 16'h6700 + 16'(i), 1'b1, 1'b0, 1'b0, "R6 R5");
    idle(13, 1'b1, "R6");

    // R1: reset with results in flight, nothing may emerge afterwards
    for (int i = 0; i < 6; i++)
      cycle(i % 3 == 0, 1'b1, 2'(i % 3), 16'h8800 + 16'(i), 1'b1, 1'b0, 1'b0, "R1");
    do_reset(1'b1);
    idle(14, 1'b1, "R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule